// File: doc/BRIEF.md
# Seven-to-One Serial Video Deserializer

This block sits behind five serial data lanes and one framing lane. All six lanes are sampled once per cycle of a fast bit clock that runs at seven times the pixel rate. The framing lane repeats a fixed seven-bit shape. The block searches the sampled framing stream for that shape, which marks the pixel boundary. It then confirms the boundary over several frames before declaring lock. Once locked, it gathers seven bits from each data lane into one 35-bit pixel word and updates that word once per pixel period.

The parallel side carries three controls: a power control, an output enable and a clock-polarity select. On this side the block presents the word and a recovered pixel clock. After power returns, a settle counter keeps the outputs quiet for a configurable number of fast cycles. Losing the framing shape for several consecutive frames drops lock, quietens the outputs and starts a new search. A disabled output is reported through an explicit drive flag rather than through tri-state values.

Top module: `sdes_rx`

## Requirements
- R1: The word packs lane L (L = 0..LANES-1) into bits [7L+6:7L]. Within a lane, the first bit received in a frame lands in bit 6 and the last lands in bit 0.
- R2: The framing lane carries 1,1,0,0,0,1,1 in arrival order. A boundary is taken after its last bit. The boundary may start at any phase. `locked` rises once LOCK_FRAMES consecutive frames (LOCK_FRAMES >= 2) show the shape at the same phase.
- R3: While locked, each frame whose framing shape is intact loads a new word one fast cycle after its last bit is sampled. `word_stb` is high for exactly that one cycle. Between strobes the word does not change.
- R4: LOSS_FRAMES consecutive frames without the framing shape clear `locked`, force data and clock outputs to zero and restart the search. Outputs are zero whenever the block is not locked.
- R5: With `out_en` low, `pix_drive` is 0 and `pix_data`/`pix_clk` are zero whatever the other controls are. `pix_drive` follows `out_en`.
- R6: With `out_en` high and `pwr_on` low, `pix_data` is all zero and `pix_clk` is low. Power-down also clears lock.
- R7: After `pwr_on` rises, the outputs stay zero until SETTLE_CYCLES fast cycles with power on have elapsed.
- R8: When the outputs are active, a word is loaded at phase 0 of a frame. With `rise_sel` high, `pix_clk` is low for phases 0..2 and high for phases 3..6. With `rise_sel` low, it is the inverse.
- R9: During synchronous reset, `locked`, `word_stb`, `pix_clk` and `pix_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | High for normal operation, low for power-down |
| out_en | input | 1 | High enables the parallel outputs |
| rise_sel | input | 1 | High: capture on the rising pixel-clock edge; low: on the falling edge |
| ck_lane | input | 1 | Sampled framing lane |
| data_lanes | input | LANES | Sampled serial data lanes, one bit each |
| pix_data | output | LANES*7 | Parallel pixel word |
| pix_clk | output | 1 | Recovered pixel clock |
| pix_drive | output | 1 | Output-drive flag that stands in for high impedance |
| word_stb | output | 1 | One-cycle strobe when a new word is loaded |
| locked | output | 1 | Frame alignment established |

## Verification
A word load and a change of clock polarity can land in the same fast cycle. Two cases are provoked. In the first, the bench waits until it sees a strobe and flips `rise_sel` at that same sampling point, so the freshly loaded word and the inverted clock level are judged together. In the second, `out_en` is toggled and lock is broken while strobes are due. A behavioural model counts framing matches, settle cycles and frame phase on its own. It compares the data, clock, drive flag, strobe and lock outputs on every cycle against the words the bench has sent.

// File: rtl/sdes_pkg.sv
package sdes_pkg;

    localparam int BITS = 7;
    localparam int PH_W = 3;
    localparam logic [BITS-1:0] CK_PATTERN = 7'b1100011;

    typedef enum logic [1:0] {
        ALN_HUNT    = 2'd0,
        ALN_CONFIRM = 2'd1,
        ALN_LOCKED  = 2'd2
    } aln_state_e;

    typedef struct packed {
        logic            locked;
        logic            capture;
        logic [PH_W-1:0] phase;
    } aln_status_t;

    function automatic logic [PH_W-1:0] next_phase(input logic [PH_W-1:0] ph);
        return (ph == PH_W'(BITS - 1)) ? '0 : ph + 1'b1;
    endfunction

    function automatic logic pclk_level(input logic [PH_W-1:0] ph);
        return (ph >= PH_W'(3));
    endfunction

endpackage

// File: rtl/sdes_frame_align.sv
module sdes_frame_align
    import sdes_pkg::*;
#(
    parameter int LOCK_FRAMES = 4,
    parameter int LOSS_FRAMES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_on,
    input  logic        ck_bit,
    output aln_status_t status
);

    localparam int CNT_MAX = (LOCK_FRAMES > LOSS_FRAMES) ? LOCK_FRAMES : LOSS_FRAMES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [BITS-1:0]  ck_win;
    aln_state_e       state;
    logic [PH_W-1:0]  phase;
    logic [CNT_W-1:0] run_cnt;
    logic             pattern_hit;
    logic             frame_end;

    assign pattern_hit = (ck_win == CK_PATTERN);
    assign frame_end   = (phase == PH_W'(BITS - 1));

    // framing-lane history, oldest sample at the MSB
    always_ff @(posedge clk) begin
        if (rst) begin
            ck_win <= '0;
        end else begin
            ck_win <= {ck_win[BITS-2:0], ck_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            state   <= ALN_HUNT;
            phase   <= '0;
            run_cnt <= '0;
        end else begin
            unique case (state)
                ALN_HUNT: begin
                    if (pattern_hit) begin
                        state   <= ALN_CONFIRM;
                        phase   <= '0;
                        run_cnt <= CNT_W'(1);
                    end
                end
                ALN_CONFIRM: begin
                    phase <= next_phase(phase);
                    if (frame_end) begin
                        if (!pattern_hit) begin
                            state   <= ALN_HUNT;
                            run_cnt <= '0;
                        end else if (run_cnt == CNT_W'(LOCK_FRAMES - 1)) begin
                            state   <= ALN_LOCKED;
                            run_cnt <= '0;
                        end else begin
                            run_cnt <= run_cnt + 1'b1;
                        end
                    end
                end
                ALN_LOCKED: begin
                    phase <= next_phase(phase);
                    if (frame_end) begin
                        if (pattern_hit) begin
                            run_cnt <= '0;
                        end else if (run_cnt == CNT_W'(LOSS_FRAMES - 1)) begin
                            state   <= ALN_HUNT;
                            run_cnt <= '0;
                        end else begin
                            run_cnt <= run_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ALN_HUNT;
            endcase
        end
    end

    always_comb begin
        status.locked  = (state == ALN_LOCKED);
        status.capture = (state == ALN_LOCKED) && frame_end && pattern_hit;
        status.phase   = phase;
    end

endmodule

// File: rtl/sdes_lane_bank.sv
module sdes_lane_bank
    import sdes_pkg::*;
#(
    parameter int LANES  = 5,
    parameter int WORD_W = LANES * BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  ser_bits,
    input  logic              capture,
    output logic [WORD_W-1:0] word,
    output logic              word_stb
);

    logic [LANES-1:0][BITS-1:0] shreg;
    logic [WORD_W-1:0]          frame_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                shreg[l] <= {shreg[l][BITS-2:0], ser_bits[l]};
            end
        end
    end

    // lane l occupies its own 7-bit field of the word
    for (genvar l = 0; l < LANES; l++) begin : g_field
        assign frame_bits[l*BITS +: BITS] = shreg[l];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word     <= '0;
            word_stb <= 1'b0;
        end else begin
            word_stb <= capture;
            if (capture) begin
                word <= frame_bits;
            end
        end
    end

endmodule

// File: rtl/sdes_out_stage.sv
module sdes_out_stage
    import sdes_pkg::*;
#(
    parameter int WORD_W        = 35,
    parameter int SETTLE_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_on,
    input  logic              out_en,
    input  logic              rise_sel,
    input  logic              locked,
    input  logic [PH_W-1:0]   phase,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] pix_data,
    output logic              pix_clk,
    output logic              pix_drive
);

    localparam int SC_W = $clog2(SETTLE_CYCLES + 1);

    logic [SC_W-1:0] settle_cnt;
    logic            settled;
    logic            active;

    assign settled = (settle_cnt == SC_W'(SETTLE_CYCLES));

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            settle_cnt <= '0;
        end else if (!settled) begin
            settle_cnt <= settle_cnt + 1'b1;
        end
    end

    assign active = out_en && pwr_on && settled && locked;

    always_comb begin
        pix_drive = out_en;
        pix_data  = '0;
        pix_clk   = 1'b0;
        if (active) begin
            pix_data = word;
            pix_clk  = rise_sel ? pclk_level(phase) : ~pclk_level(phase);
        end
    end

endmodule

// File: rtl/sdes_rx.sv
module sdes_rx
    import sdes_pkg::*;
#(
    parameter int LANES         = 5,
    parameter int LOCK_FRAMES   = 4,
    parameter int LOSS_FRAMES   = 3,
    parameter int SETTLE_CYCLES = 1024
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pwr_on,
    input  logic                    out_en,
    input  logic                    rise_sel,
    input  logic                    ck_lane,
    input  logic [LANES-1:0]        data_lanes,
    output logic [LANES*BITS-1:0]   pix_data,
    output logic                    pix_clk,
    output logic                    pix_drive,
    output logic                    word_stb,
    output logic                    locked
);

    localparam int WORD_W = LANES * BITS;

    aln_status_t       aln;
    logic [WORD_W-1:0] cap_word;

    sdes_frame_align #(
        .LOCK_FRAMES (LOCK_FRAMES),
        .LOSS_FRAMES (LOSS_FRAMES)
    ) u_align (
        .clk    (clk),
        .rst    (rst),
        .pwr_on (pwr_on),
        .ck_bit (ck_lane),
        .status (aln)
    );

    sdes_lane_bank #(
        .LANES  (LANES),
        .WORD_W (WORD_W)
    ) u_lanes (
        .clk      (clk),
        .rst      (rst),
        .ser_bits (data_lanes),
        .capture  (aln.capture),
        .word     (cap_word),
        .word_stb (word_stb)
    );

    sdes_out_stage #(
        .WORD_W        (WORD_W),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .pwr_on    (pwr_on),
        .out_en    (out_en),
        .rise_sel  (rise_sel),
        .locked    (aln.locked),
        .phase     (aln.phase),
        .word      (cap_word),
        .pix_data  (pix_data),
        .pix_clk   (pix_clk),
        .pix_drive (pix_drive)
    );

    assign locked = aln.locked;

endmodule

// File: rtl/sdes_rx_chk.sv
module sdes_rx_chk #(
    parameter int WORD_W = 35
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_on,
    input logic              out_en,
    input logic [WORD_W-1:0] pix_data,
    input logic              pix_clk,
    input logic              pix_drive,
    input logic              word_stb,
    input logic              locked,
    input logic [WORD_W-1:0] cap_word
);

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (!pix_drive && pix_data == '0 && !pix_clk)); // R5

    AST_POWERDOWN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_en && !pwr_on) |-> (pix_drive && pix_data == '0 && !pix_clk)); // R6

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb); // R3

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !word_stb |-> $stable(cap_word)); // R3

    AST_STROBE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> locked); // R3

    AST_CLOCK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (pix_clk || pix_data != '0) |-> locked); // R4

endmodule

bind sdes_rx sdes_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_on    (pwr_on),
    .out_en    (out_en),
    .pix_data  (pix_data),
    .pix_clk   (pix_clk),
    .pix_drive (pix_drive),
    .word_stb  (word_stb),
    .locked    (locked),
    .cap_word  (cap_word)
);

// File: tb/tb_sdes_rx.sv
`timescale 1ns/1ps
module tb_sdes_rx;

    localparam int LANES  = 5;
    localparam int WORD_W = LANES * 7;
    localparam int LOCKN  = 3;
    localparam int LOSSN  = 2;
    localparam int SETTLE = 40;
    localparam logic [6:0] SHAPE = 7'b1100011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_on = 1'b1;
    logic out_en = 1'b1;
    logic rise_sel = 1'b1;
    logic ck_lane = 1'b0;
    logic [LANES-1:0]  data_lanes = '0;
    logic [WORD_W-1:0] pix_data;
    logic pix_clk, pix_drive, word_stb, locked;

    always #10 clk = ~clk;

    sdes_rx #(
        .LANES         (LANES),
        .LOCK_FRAMES   (LOCKN),
        .LOSS_FRAMES   (LOSSN),
        .SETTLE_CYCLES (SETTLE)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .pwr_on     (pwr_on),
        .out_en     (out_en),
        .rise_sel   (rise_sel),
        .ck_lane    (ck_lane),
        .data_lanes (data_lanes),
        .pix_data   (pix_data),
        .pix_clk    (pix_clk),
        .pix_drive  (pix_drive),
        .word_stb   (word_stb),
        .locked     (locked)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // stimulus state
    int                send_pos = 3;
    logic [WORD_W-1:0] send_word = '0;
    int                frame_no = 0;
    int                word_mode = 0;
    bit                break_shape = 1'b0;

    // reference model state
    int                m_mode = 0;      // 0 searching, 1 confirming, 2 aligned
    int                m_ph = 0;
    int                m_good = 0;
    int                m_bad = 0;
    int                m_sc = 0;
    bit                m_stb = 1'b0;
    logic [WORD_W-1:0] m_word = '0;
    logic [6:0]        m_hist = '0;
    logic [WORD_W-1:0] last_done = '0;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [WORD_W-1:0] make_word(input int mode, input int n);
        logic [63:0] v;
        case (mode)
            1: v = '1;
            2: v = n[0] ? 64'hAAAA_AAAA_AAAA_AAAA : 64'h5555_5555_5555_5555;
            3: v = 64'(n) * 64'h0000_0001_0204_0811;
            default: v = {$urandom(), $urandom()};
        endcase
        return WORD_W'(v);
    endfunction

    task automatic model_step();
        bit shape_seen;
        bit wrap;
        shape_seen = (m_hist == SHAPE);
        m_stb = 1'b0;
        if (rst || !pwr_on) begin
            m_mode = 0; m_ph = 0; m_good = 0; m_bad = 0;
            if (rst) m_word = '0;
        end else begin
            wrap = (m_ph == 6);
            if (m_mode == 0) begin
                if (shape_seen) begin m_mode = 1; m_ph = 0; m_good = 1; end
            end else begin
                m_ph = wrap ? 0 : m_ph + 1;
                if (wrap && m_mode == 1) begin
                    if (!shape_seen) begin m_mode = 0; end
                    else if (m_good + 1 >= LOCKN) begin m_mode = 2; m_bad = 0; end
                    else m_good++;
                end else if (wrap && m_mode == 2) begin
                    if (shape_seen) begin m_bad = 0; m_word = last_done; m_stb = 1'b1; end
                    else if (m_bad + 1 >= LOSSN) begin m_mode = 0; m_ph = 0; m_bad = 0; end
                    else m_bad++;
                end
            end
        end
        if (rst) m_hist = '0;
        else m_hist = {m_hist[5:0], ck_lane};
        if (send_pos == 6) last_done = send_word;
        if (rst || !pwr_on) m_sc = 0;
        else if (m_sc < SETTLE) m_sc++;
    endtask

    task automatic compare_all();
        bit    act;
        bit    lvl;
        string tag;
        act = out_en && pwr_on && (m_sc == SETTLE) && (m_mode == 2);
        lvl = (m_ph >= 3);
        if (!out_en) tag = "R5";
        else if (!pwr_on) tag = "R6";
        else if (m_sc != SETTLE) tag = "R7";
        else if (m_mode != 2) tag = "R4";
        else tag = "R1";
        chk(tag, 64'(pix_data), act ? 64'(m_word) : 64'd0);
        chk("R5", 64'(pix_drive), 64'(out_en));
        chk(act ? "R8" : tag, 64'(pix_clk), act ? 64'(rise_sel ? lvl : !lvl) : 64'd0);
        chk("R3", 64'(word_stb), 64'(m_stb));
        chk("R2", 64'(locked), 64'(m_mode == 2));
    endtask

    task automatic drive_next();
        if (send_pos == 6) begin
            send_pos  = 0;
            frame_no++;
            send_word = make_word(word_mode, frame_no);
        end else begin
            send_pos++;
        end
        ck_lane = break_shape ? 1'b0 : SHAPE[6 - send_pos];
        for (int l = 0; l < LANES; l++) begin
            data_lanes[l] = send_word[l*7 + 6 - send_pos];
        end
    endtask

    task automatic tick();
        @(negedge clk);
        model_step();
        compare_all();
        drive_next();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic run_until_stb();
        for (int i = 0; i < 40; i++) begin
            tick();
            if (word_stb) break;
        end
    endtask

    initial begin
        run(4);
        chk("R9", {61'd0, locked, word_stb, pix_clk}, 64'd0);
        chk("R9", 64'(pix_data), 64'd0);
        rst = 1'b0;
        run(84);
        chk("R2", 64'(locked), 64'd1);
        run(70);
        word_mode = 1; run(35);
        word_mode = 2; run(35);
        word_mode = 3; run(35);
        word_mode = 0;
        // polarity flip on the same cycle a new word appears
        run_until_stb();
        rise_sel = 1'b0;
        run(1);
        chk("R8", 64'(pix_clk), 64'd1);
        run(48);
        run_until_stb();
        rise_sel = 1'b1;
        run(20);
        out_en = 1'b0; run(30);
        chk("R5", {62'd0, pix_drive, pix_clk}, 64'd0);
        out_en = 1'b1; run(10);
        break_shape = 1'b1; run(21);
        chk("R4", 64'(locked), 64'd0);
        break_shape = 1'b0; run(42);
        chk("R2", 64'(locked), 64'd1);
        pwr_on = 1'b0; run(20);
        chk("R6", 64'(locked), 64'd0);
        pwr_on = 1'b1; run(10);
        chk("R7", 64'(pix_data), 64'd0);
        run(60);
        chk("R7", 64'(locked), 64'd1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule